// File: doc/BRIEF.md
# ADC Offset and Gain Correction Stage

This block sits after an ADC decimation filter and corrects each raw conversion before it is handed on. For every conversion it subtracts a stored per-channel offset from the signed raw word, multiplies the difference by a stored per-channel unsigned fixed-point gain, and reduces the product to the output word width. The result is clamped at the output range, registered and marked valid for one cycle.

A host loads the offset and gain for any channel through a single-cycle write port. After reset the block passes data straight through: every offset is zero and every gain is 1.0. The output keeps the top bits of the 32-bit raw scale. A gain above one therefore lifts lower filter bits into the output word, which narrows the full-scale span. The offset is removed before the multiply, so the gain also scales it.

Top module: `adc_gain_offset_corr`

## Requirements
- R1: After reset every channel's offset is 0 and gain is 0x01000000 (1.0). A conversion of raw value X then yields floor(X / 2^(32-OUT_W)), which is 0x123456 for X = 0x12345678 with OUT_W = 24. During reset out_valid and out_data are 0.
- R2: The corrected output equals floor((raw - offset) * gain / 2^(24 + 32 - OUT_W)). Here raw and offset are signed 32-bit, and gain is unsigned with 24 fractional bits. A gain of 0x03E80000 (3.90625) maps raw 0x00A00000 to 0x027100.
- R3: The offset is subtracted before the multiply, so its effect on the output is scaled by the channel's gain.
- R4: A result above 2^(OUT_W-1)-1 or below -2^(OUT_W-1) is clamped to that limit and never wraps.
- R5: Each channel has its own offset and gain. A conversion uses only the pair of the channel given on in_ch.
- R6: A write with cfg_sel = 0 loads the offset and a write with cfg_sel = 1 loads the gain of channel cfg_ch. The new value applies from the next conversion accepted after the write cycle. A conversion accepted in the same cycle as the write still uses the old value.
- R7: out_valid is high exactly two clock cycles after the cycle in which in_valid is high, for one cycle per accepted conversion. Back-to-back conversions give back-to-back results. out_data holds its value while out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | CH_W | Channel of the register write |
| cfg_sel | input | 1 | 0 selects offset, 1 selects gain |
| cfg_data | input | 32 | Write data |
| in_valid | input | 1 | Raw conversion present |
| in_ch | input | CH_W | Channel of the raw conversion |
| in_raw | input | 32 | Signed raw filter output |
| out_valid | output | 1 | Corrected word valid, one cycle |
| out_data | output | OUT_W | Signed corrected output word |

## Verification
The assertions take for granted that cfg_ch and in_ch always name an existing channel. This holds because the channel count is a power of two. They also assume all inputs are known once reset is released. The sign check assumes that a nonzero difference with a nonzero gain can never round to a positive value when the difference is negative. The stimulus draws channels by masking $urandom to the channel index width. It holds in_valid and cfg_we low during reset and drives every input on the falling edge. Conversions and register writes are mixed at random, including writes in the same cycle as a conversion on the same channel.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  typedef enum logic {
    SEL_OFFSET = 1'b0,
    SEL_GAIN   = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/adc_corr_regfile.sv
module adc_corr_regfile #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  parameter int FRAC_W = 24,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [DATA_W-1:0] rd_off,
  output logic [DATA_W-1:0] rd_gain
);
  import adc_corr_pkg::*;

  localparam logic [DATA_W-1:0] GAIN_ONE = DATA_W'(1) << FRAC_W;

  logic [DATA_W-1:0] off_mem  [NUM_CH];
  logic [DATA_W-1:0] gain_mem [NUM_CH];

  // Storage: synchronous reset to defaults, one write port
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) begin
        off_mem[i]  <= '0;
        gain_mem[i] <= GAIN_ONE;
      end
    end else if (wr_en) begin
      if (cfg_sel_e'(wr_sel) == SEL_GAIN) gain_mem[wr_ch] <= wr_data;
      else                                off_mem[wr_ch]  <= wr_data;
    end
  end

  // Registered read: returns the contents before a same-cycle write
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_off  <= '0;
      rd_gain <= GAIN_ONE;
    end else if (rd_en) begin
      rd_off  <= off_mem[rd_ch];
      rd_gain <= gain_mem[rd_ch];
    end
  end

  // R1
  rst_default_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (off_mem[0] == '0 && gain_mem[0] == GAIN_ONE));

  // R6
  gain_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel) |=> gain_mem[$past(wr_ch)] == $past(wr_data));

  // R6
  off_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel) |=> off_mem[$past(wr_ch)] == $past(wr_data));
endmodule

// File: rtl/adc_corr_scale.sv
module adc_corr_scale #(
  parameter int RAW_W  = 32,
  parameter int GAIN_W = 32,
  parameter int FRAC_W = 24,
  parameter int OUT_W  = 24,
  localparam int PROD_W = RAW_W + GAIN_W + 2,
  localparam int SHIFT  = FRAC_W + RAW_W - OUT_W
) (
  input  logic signed [RAW_W-1:0]  raw,
  input  logic        [RAW_W-1:0]  off,
  input  logic        [GAIN_W-1:0] gain,
  output logic signed [PROD_W-1:0] scaled
);
  logic signed [RAW_W:0]  diff;
  logic        [PROD_W-1:0] diff_ext;
  logic        [PROD_W-1:0] gain_ext;
  logic        [PROD_W-1:0] prod;

  always_comb begin
    diff     = {raw[RAW_W-1], raw} - {off[RAW_W-1], off};
    diff_ext = {{(GAIN_W + 1){diff[RAW_W]}}, diff};
    gain_ext = {{(RAW_W + 1){1'b0}}, gain};
    prod     = diff_ext * gain_ext;
    scaled   = $signed(prod) >>> SHIFT;
  end
endmodule

// File: rtl/adc_corr_sat.sv
module adc_corr_sat #(
  parameter int IN_W  = 66,
  parameter int OUT_W = 24
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam logic signed [IN_W-1:0] HI = {{(IN_W - OUT_W + 1){1'b0}}, {(OUT_W - 1){1'b1}}};
  localparam logic signed [IN_W-1:0] LO = {{(IN_W - OUT_W + 1){1'b1}}, {(OUT_W - 1){1'b0}}};

  always_comb begin
    if (din > HI)      dout = HI[OUT_W-1:0];
    else if (din < LO) dout = LO[OUT_W-1:0];
    else               dout = din[OUT_W-1:0];
  end
endmodule

// File: rtl/adc_gain_offset_corr.sv
module adc_gain_offset_corr #(
  parameter int NUM_CH = 4,
  parameter int RAW_W  = 32,
  parameter int FRAC_W = 24,
  parameter int OUT_W  = 24,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int PROD_W = 2 * RAW_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [CH_W-1:0]         cfg_ch,
  input  logic                    cfg_sel,
  input  logic [RAW_W-1:0]        cfg_data,
  input  logic                    in_valid,
  input  logic [CH_W-1:0]         in_ch,
  input  logic signed [RAW_W-1:0] in_raw,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  generate
    if (OUT_W != 16 && OUT_W != 24) begin : g_bad_width
      initial $error("OUT_W must be 16 or 24");
    end
  endgenerate

  logic                    s1_valid;
  logic signed [RAW_W-1:0] s1_raw;
  logic [RAW_W-1:0]        s1_off;
  logic [RAW_W-1:0]        s1_gain;
  logic signed [PROD_W-1:0] scaled;
  logic signed [OUT_W-1:0]  clamped;

  adc_corr_regfile #(
    .NUM_CH (NUM_CH),
    .DATA_W (RAW_W),
    .FRAC_W (FRAC_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_ch   (cfg_ch),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_data),
    .rd_en   (in_valid),
    .rd_ch   (in_ch),
    .rd_off  (s1_off),
    .rd_gain (s1_gain)
  );

  // Stage 1: capture raw word alongside the coefficient read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_raw   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) s1_raw <= in_raw;
    end
  end

  adc_corr_scale #(
    .RAW_W  (RAW_W),
    .GAIN_W (RAW_W),
    .FRAC_W (FRAC_W),
    .OUT_W  (OUT_W)
  ) u_scale (
    .raw    (s1_raw),
    .off    (s1_off),
    .gain   (s1_gain),
    .scaled (scaled)
  );

  adc_corr_sat #(
    .IN_W  (PROD_W),
    .OUT_W (OUT_W)
  ) u_sat (
    .din  (scaled),
    .dout (clamped)
  );

  // Stage 2: output register
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_data <= clamped;
    end
  end

  // R7
  in_to_s1_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_valid);

  // R7
  out_source_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(s1_valid));

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  // R4
  sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_gain != '0 && s1_raw != $signed(s1_off))
      |=> out_data[OUT_W-1] == $past(s1_raw < $signed(s1_off)));
endmodule

// File: tb/adc_gain_offset_corr_bench.sv
module adc_gain_offset_corr_bench;
  localparam int NUM_CH = 4;
  localparam int CH_W   = 2;
  localparam int OUT_W  = 24;
  localparam int SHIFT  = 24 + 32 - OUT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [CH_W-1:0] cfg_ch = '0;
  logic cfg_sel = 1'b0;
  logic [31:0] cfg_data = '0;
  logic in_valid = 1'b0;
  logic [CH_W-1:0] in_ch = '0;
  logic signed [31:0] in_raw = '0;
  logic out_valid;
  logic signed [OUT_W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] off_m  [NUM_CH];
  logic [31:0] gain_m [NUM_CH];

  always #4 clk = ~clk;

  adc_gain_offset_corr #(.NUM_CH(NUM_CH), .OUT_W(OUT_W)) u_adc_gain_offset_corr (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .in_valid(in_valid), .in_ch(in_ch), .in_raw(in_raw),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic signed [OUT_W-1:0] model(logic [31:0] raw, logic [31:0] off,
                                                   logic [31:0] gain);
    logic signed [65:0] d, g, p, s;
    logic signed [65:0] hi, lo;
    d  = $signed({{34{raw[31]}}, raw}) - $signed({{34{off[31]}}, off});
    g  = $signed({34'b0, gain});
    p  = d * g;
    s  = p >>> SHIFT;
    hi = 66'sd8388607;
    lo = -66'sd8388608;
    if (s > hi) return hi[OUT_W-1:0];
    if (s < lo) return lo[OUT_W-1:0];
    return s[OUT_W-1:0];
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic [CH_W-1:0] ch, logic sel, logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = ch; cfg_sel = sel; cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) gain_m[ch] = data; else off_m[ch] = data;
  endtask

  // One conversion; output sampled on the second falling edge after the accepting edge
  task automatic convert(logic [CH_W-1:0] ch, logic [31:0] raw, string tag);
    logic signed [OUT_W-1:0] exp;
    exp = model(raw, off_m[ch], gain_m[ch]);
    @(negedge clk);
    in_valid = 1'b1; in_ch = ch; in_raw = raw;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R7 early valid", 32'(out_valid), 32'd0);
    @(negedge clk);
    check(out_valid == 1'b1, "R7 valid at +2", 32'(out_valid), 32'd1);
    check(out_data == exp, tag, 32'(out_data), 32'(exp));
    @(negedge clk);
    check(out_valid == 1'b0, "R7 single pulse", 32'(out_valid), 32'd0);
    check(out_data == exp, "R7 data held", 32'(out_data), 32'(exp));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic signed [OUT_W-1:0] ea, eb;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NUM_CH; i++) begin
      off_m[i] = 32'h0;
      gain_m[i] = 32'h0100_0000;
    end
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0 && out_data == '0, "R1 reset outputs", 32'(out_data), 32'd0);
    rst = 1'b0;

    // R1: pass-through defaults
    convert(2'd2, 32'h1234_5678, "R1 default pass");
    check(out_data == 24'h123456, "R1 literal", 32'(out_data), 32'h123456);
    convert(2'd3, 32'hFFFF_FF00, "R1 negative pass");

    // R2: span narrowing gain
    cfg_write(2'd1, 1'b1, 32'h03E8_0000);
    convert(2'd1, 32'h00A0_0000, "R2 gain 3.90625");
    check(out_data == 24'h027100, "R2 literal", 32'(out_data), 32'h027100);
    convert(2'd1, 32'hFFF0_0123, "R2 negative scaled");

    // R3: offset scaled by gain
    cfg_write(2'd0, 1'b1, 32'h0200_0000);
    cfg_write(2'd0, 1'b0, 32'h0000_0100);
    convert(2'd0, 32'h0000_1100, "R3 offset then gain");
    check(out_data == 24'h000020, "R3 literal", 32'(out_data), 32'h20);

    // R4: saturation both ways
    convert(2'd0, 32'h7FFF_FFFF, "R4 clamp high");
    check(out_data == 24'h7FFFFF, "R4 max code", 32'(out_data), 32'h7FFFFF);
    convert(2'd0, 32'h8000_0000, "R4 clamp low");
    check(out_data == 24'h800000, "R4 min code", 32'(out_data), 32'h800000);
    cfg_write(2'd3, 1'b0, 32'h8000_0000);
    convert(2'd3, 32'h7FFF_FFFF, "R4 wide difference clamp");

    // R5: other channels untouched
    convert(2'd2, 32'h0000_1100, "R5 channel isolation");
    check(out_data == 24'h000011, "R5 literal", 32'(out_data), 32'h11);

    // R6: write in the same cycle as a conversion uses the old gain
    ea = model(32'h0010_0000, off_m[2], gain_m[2]);
    @(negedge clk);
    in_valid = 1'b1; in_ch = 2'd2; in_raw = 32'h0010_0000;
    cfg_we = 1'b1; cfg_ch = 2'd2; cfg_sel = 1'b1; cfg_data = 32'h0400_0000;
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    gain_m[2] = 32'h0400_0000;
    @(negedge clk);
    check(out_valid && out_data == ea, "R6 same-cycle old value", 32'(out_data), 32'(ea));
    convert(2'd2, 32'h0010_0000, "R6 next conversion new value");

    // R7: back-to-back conversions
    ea = model(32'h0123_4567, off_m[1], gain_m[1]);
    eb = model(32'hF000_0000, off_m[3], gain_m[3]);
    @(negedge clk);
    in_valid = 1'b1; in_ch = 2'd1; in_raw = 32'h0123_4567;
    @(negedge clk);
    in_ch = 2'd3; in_raw = 32'hF000_0000;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_data == ea, "R7 back-to-back first", 32'(out_data), 32'(ea));
    @(negedge clk);
    check(out_valid && out_data == eb, "R7 back-to-back second", 32'(out_data), 32'(eb));

    // Random mix (R2, R5, R6)
    for (int n = 0; n < 300; n++) begin
      logic [CH_W-1:0] ch;
      logic [31:0] v;
      ch = CH_W'($urandom & (NUM_CH - 1));
      v  = $urandom;
      case ($urandom % 4)
        0: cfg_write(ch, 1'b1, ($urandom % 2) ? (v & 32'h07FF_FFFF) : v);
        1: cfg_write(ch, 1'b0, ($urandom % 2) ? {{12{v[19]}}, v[19:0]} : v);
        default: convert(ch, v, "R2 random conversion");
      endcase
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule